// File: doc/BRIEF.md
# Pairwise Variance Reduction Tree

This block watches a stream of signed fixed-point samples, one per clock cycle, and condenses it into statistics records. Each record covers one aligned block of 2^LEVELS consecutive samples and carries two values: the exact sum of the block, and the block's second moment (the sum of squared deviations from the block mean) in fixed point with `FRAC_W` fractional bits. The output volume is therefore 2^LEVELS times smaller than the input. A later consumer merges the records into running mean and variance figures.

The block is a chain of `LEVELS` combining stages. Stage L joins two adjacent partial results, each covering 2^(L-1) samples. The older partner is the stage's own input, held back by a delay line of 2^(L-1) entries. Because of this, a chain of `LEVELS` combiners does the work of a full binary tree of 2^LEVELS - 1 combiners. Two partials with sums Ta and Tb and second moments Sa and Sb, each of m samples, merge into sum Ta+Tb and second moment Sa + Sb + (Ta-Tb)^2/(2m). Since 2m is a power of two, the division is a shift. The first stage is a simpler variant, because a lone sample has no spread.

A valid flag travels through every delay line. A phase counter at the output passes only the records of aligned, non-overlapping blocks.

Top module: `pairvar_tree`

## Requirements
- R1: While `rst_n` is low, and after reset until the first complete block, `rec_valid_o` is 0. No record is ever issued for a block that contains a sample captured before reset was released.
- R2: Samples are numbered from 0, starting with the sample presented at the first rising edge after reset is released. The record for the block ending at sample n is valid in the cycle after rising edge n+LEVELS+1. The first record therefore follows edge 2^LEVELS+LEVELS.
- R3: Records are issued only for the aligned blocks k*2^LEVELS .. (k+1)*2^LEVELS-1. They arrive exactly 2^LEVELS cycles apart and in order of k.
- R4: `rec_sum_o` is the exact two's-complement sum of the block's samples, `SUM_W` = DATA_W+LEVELS bits wide.
- R5: At the first level, samples a and b contribute floor((a-b)^2 * 2^FRAC_W / 2) to the second moment. A block whose pair sums are all equal therefore has a second moment equal to the sum of these pair terms.
- R6: At level L (L>=2), partials (Ta,Sa) and (Tb,Sb) merge to Sa + Sb + floor((Ta-Tb)^2 * 2^FRAC_W / 2^L). `rec_m2_o` is this unsigned result at level LEVELS, `M2_W` = 2*DATA_W+2*LEVELS+FRAC_W bits wide. A constant block gives 0.
- R7: No stage overflows. This holds for the full-scale cases: blocks of all minimum samples, blocks of all maximum samples, and blocks alternating minimum and maximum.
- R8: A reset asserted in the middle of a block discards all partial state. After release, the timing of R2 applies again from the new sample 0.
- R9: When `rec_valid_o` is 0, `rec_sum_o` and `rec_m2_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every edge takes one sample |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | DATA_W | Signed input sample |
| rec_valid_o | output | 1 | High for one cycle per aligned block record |
| rec_sum_o | output | SUM_W | Signed block sum |
| rec_m2_o | output | M2_W | Unsigned block second moment, FRAC_W fractional bits |

## Verification
Two events can fall in the same cycle. The last stage can produce its very first valid partial result, and the output phase counter must decide on that same edge whether to emit it. A fault in either the valid flags or the phase alignment shows up as an early, late or misaligned record. The bench provokes this after every reset, including resets placed in the middle of a block, and checks on every cycle whether a record was expected. Record contents are then compared against sums and floored pairwise merges that the bench computes itself, using patterns that isolate the first-level term, the merge term and the full-scale extremes.

// File: rtl/pairvar_pkg.sv
package pairvar_pkg;

    // Width of a partial sum covering 2^lvl samples of dw bits.
    function automatic int sum_w(input int dw, input int lvl);
        return dw + lvl;
    endfunction

    // Width of a partial second moment covering 2^lvl samples.
    function automatic int m2_w(input int dw, input int lvl, input int frac);
        return 2 * dw + 2 * lvl + frac;
    endfunction

endpackage

// File: rtl/pairvar_stage.sv
module pairvar_stage
    import pairvar_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int FRAC_W = 2,
    parameter int LVL    = 1,
    parameter int LEVELS = 3,
    localparam int TB    = sum_w(DATA_W, LEVELS),
    localparam int SB    = m2_w(DATA_W, LEVELS, FRAC_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [TB-1:0] in_sum,
    input  logic [SB-1:0] in_m2,
    output logic          out_vld,
    output logic [TB-1:0] out_sum,
    output logic [SB-1:0] out_m2
);

    localparam int  TI    = sum_w(DATA_W, LVL - 1);
    localparam int  TO    = sum_w(DATA_W, LVL);
    localparam int  SI    = m2_w(DATA_W, LVL - 1, FRAC_W);
    localparam int  SO    = m2_w(DATA_W, LVL, FRAC_W);
    localparam int  DEPTH = 1 << (LVL - 1);
    localparam bit  FIRST = (LVL == 1);

    typedef struct packed {
        logic [DEPTH-1:0]         dv;   // delayed valid flags
        logic [DEPTH-1:0][TI-1:0] ds;   // delayed partial sums
        logic [DEPTH-1:0][SI-1:0] dm;   // delayed partial second moments
        logic                     ov;
        logic [TO-1:0]            os;
        logic [SO-1:0]            om;
    } stage_t;

    stage_t st_d, st_q;

    logic signed [TI-1:0] cur_sum, old_sum;
    logic signed [TO-1:0] diff;
    logic        [TO-1:0] mag;
    logic      [2*TO-1:0] sq;
    logic        [SO-1:0] term;
    logic        [SI-1:0] m2_in;
    logic                 unused_hi;

    // Upper bus bits only carry sign or zero extension at this level.
    assign unused_hi = ^{in_sum[TB-1:TI], in_m2[SB-1:SI]};

    always_comb begin
        st_d    = st_q;
        cur_sum = $signed(in_sum[TI-1:0]);
        old_sum = $signed(st_q.ds[DEPTH-1]);
        // a single sample has no spread, so level one never adds moments
        m2_in   = FIRST ? '0 : in_m2[SI-1:0];

        diff = TO'(cur_sum) - TO'(old_sum);
        mag  = diff[TO-1] ? TO'(-diff) : TO'(diff);
        sq   = (2*TO)'(mag) * (2*TO)'(mag);
        term = (SO'(sq) << FRAC_W) >> LVL;

        for (int i = DEPTH - 1; i >= 1; i--) begin
            st_d.dv[i] = st_q.dv[i-1];
            st_d.ds[i] = st_q.ds[i-1];
            st_d.dm[i] = st_q.dm[i-1];
        end
        st_d.dv[0] = in_vld;
        st_d.ds[0] = cur_sum;
        st_d.dm[0] = m2_in;

        st_d.ov = in_vld && st_q.dv[DEPTH-1];
        st_d.os = TO'(cur_sum) + TO'(old_sum);
        if (FIRST) begin
            st_d.om = term;
        end else begin
            st_d.om = SO'(m2_in) + SO'(st_q.dm[DEPTH-1]) + term;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.ov;
    assign out_sum = TB'($signed(st_q.os));
    assign out_m2  = SB'(st_q.om);

endmodule

// File: rtl/pairvar_emit.sv
module pairvar_emit #(
    parameter int LEVELS = 3,
    parameter int SUM_W  = 11,
    parameter int M2_W   = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [SUM_W-1:0] in_sum,
    input  logic [M2_W-1:0]  in_m2,
    output logic             rec_vld,
    output logic [SUM_W-1:0] rec_sum,
    output logic [M2_W-1:0]  rec_m2
);

    typedef struct packed {
        logic [LEVELS-1:0] phase;
        logic              rv;
        logic [SUM_W-1:0]  rs;
        logic [M2_W-1:0]   rm;
    } emit_t;

    emit_t em_d, em_q;

    always_comb begin
        em_d = em_q;
        if (in_vld) begin
            em_d.phase = em_q.phase + 1'b1;
        end
        // the first full-depth partial is block 0; every 2^LEVELS-th after
        em_d.rv = in_vld && (em_q.phase == '0);
        em_d.rs = em_d.rv ? in_sum : '0;
        em_d.rm = em_d.rv ? in_m2  : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            em_q <= '0;
        end else begin
            em_q <= em_d;
        end
    end

    assign rec_vld = em_q.rv;
    assign rec_sum = em_q.rs;
    assign rec_m2  = em_q.rm;

endmodule

// File: rtl/pairvar_tree.sv
module pairvar_tree
    import pairvar_pkg::*;
#(
    parameter int  DATA_W = 8,
    parameter int  LEVELS = 3,
    parameter int  FRAC_W = 2,
    localparam int SUM_W  = sum_w(DATA_W, LEVELS),
    localparam int M2_W   = m2_w(DATA_W, LEVELS, FRAC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    output logic              rec_valid_o,
    output logic [SUM_W-1:0]  rec_sum_o,
    output logic [M2_W-1:0]   rec_m2_o
);

    typedef struct packed {
        logic              xv;
        logic [DATA_W-1:0] x;
    } in_t;

    in_t in_d, in_q;

    logic             vb [0:LEVELS];
    logic [SUM_W-1:0] sb [0:LEVELS];
    logic [M2_W-1:0]  mb [0:LEVELS];

    always_comb begin
        in_d    = in_q;
        in_d.xv = 1'b1;
        in_d.x  = sample_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= in_d;
        end
    end

    assign vb[0] = in_q.xv;
    assign sb[0] = SUM_W'($signed(in_q.x));
    assign mb[0] = '0;

    for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
        pairvar_stage #(
            .DATA_W (DATA_W),
            .FRAC_W (FRAC_W),
            .LVL    (l),
            .LEVELS (LEVELS)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (vb[l-1]),
            .in_sum  (sb[l-1]),
            .in_m2   (mb[l-1]),
            .out_vld (vb[l]),
            .out_sum (sb[l]),
            .out_m2  (mb[l])
        );
    end

    pairvar_emit #(
        .LEVELS (LEVELS),
        .SUM_W  (SUM_W),
        .M2_W   (M2_W)
    ) u_emit (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (vb[LEVELS]),
        .in_sum  (sb[LEVELS]),
        .in_m2   (mb[LEVELS]),
        .rec_vld (rec_valid_o),
        .rec_sum (rec_sum_o),
        .rec_m2  (rec_m2_o)
    );

endmodule

// File: rtl/pairvar_chk.sv
module pairvar_chk #(
    parameter int DATA_W = 8,
    parameter int LEVELS = 3,
    parameter int FRAC_W = 2,
    parameter int SUM_W  = DATA_W + LEVELS,
    parameter int M2_W   = 2 * DATA_W + 2 * LEVELS + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_valid_o,
    input logic [SUM_W-1:0]  rec_sum_o,
    input logic [M2_W-1:0]   rec_m2_o
);

    localparam int BLK     = 1 << LEVELS;
    localparam int FIRST_C = BLK + LEVELS + 1;
    localparam int MAXS    = BLK * ((1 << (DATA_W - 1)) - 1);
    localparam int MINS    = -BLK * (1 << (DATA_W - 1));

    logic [31:0] cyc_q, gap_q;
    logic        seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (cyc_q <= 32'(FIRST_C)) cyc_q <= cyc_q + 1'b1;
            if (rec_valid_o) begin
                gap_q  <= 32'd1;
                seen_q <= 1'b1;
            end else if (gap_q <= 32'(BLK)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    p_no_early_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> (cyc_q >= 32'(FIRST_C)));

    p_first_record_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 32'(FIRST_C)) |-> rec_valid_o);

    p_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_o && seen_q) |-> (gap_q == 32'(BLK)));

    p_sum_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> (($signed(rec_sum_o) <= MAXS) && ($signed(rec_sum_o) >= MINS)));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid_o |-> ((rec_sum_o == '0) && (rec_m2_o == '0)));

endmodule

bind pairvar_tree pairvar_chk #(
    .DATA_W (DATA_W),
    .LEVELS (LEVELS),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rec_valid_o (rec_valid_o),
    .rec_sum_o   (rec_sum_o),
    .rec_m2_o    (rec_m2_o)
);

// File: tb/pairvar_tree_tb.sv
module pairvar_tree_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int LEVELS = 3;
    localparam int FRAC_W = 2;
    localparam int SUM_W  = DATA_W + LEVELS;
    localparam int M2_W   = 2 * DATA_W + 2 * LEVELS + FRAC_W;
    localparam int BLK    = 1 << LEVELS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] sample_i = '0;
    logic              rec_valid_o;
    logic [SUM_W-1:0]  rec_sum_o;
    logic [M2_W-1:0]   rec_m2_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pairvar_tree #(.DATA_W(DATA_W), .LEVELS(LEVELS), .FRAC_W(FRAC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i),
        .rec_valid_o(rec_valid_o), .rec_sum_o(rec_sum_o), .rec_m2_o(rec_m2_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Stimulus patterns, sample index n.
    function automatic longint pat(input int p, input int n);
        longint d, h;
        int blk;
        case (p)
            0: return longint'((n * 7) & 255) - 128;
            1: begin  // R5: equal pair sums, pair difference swept
                d = longint'((n >> 1) % 255) - 127;
                return (n % 2 == 0) ? d : -d;
            end
            2: begin  // R7: full-scale blocks
                blk = n / BLK;
                if (blk % 3 == 0) return (n % 2 == 0) ? -128 : 127;
                else if (blk % 3 == 1) return -128;
                else return 127;
            end
            3: begin
                h = (longint'(n) * 1103515245 + 12345) >> 16;
                return (h & 255) - 128;
            end
            default: return 42;
        endcase
    endfunction

    // Expected record of block k: exact sums, floored pairwise merges.
    task automatic expect_block(input int p, input int k,
                                output longint es, output longint em);
        longint t [0:BLK-1];
        longint s [0:BLK-1];
        longint d;
        int cnt;
        for (int i = 0; i < BLK; i++) begin
            t[i] = pat(p, k * BLK + i);
            s[i] = 0;
        end
        cnt = BLK;
        for (int lvl = 1; lvl <= LEVELS; lvl++) begin
            cnt = cnt / 2;
            for (int j = 0; j < cnt; j++) begin
                d    = t[2*j] - t[2*j+1];
                s[j] = s[2*j] + s[2*j+1] + (((d * d) << FRAC_W) >>> lvl);
                t[j] = t[2*j] + t[2*j+1];
            end
        end
        es = t[0];
        em = s[0];
    endtask

    task automatic run_phase(input int p, input int ns, input string mreq, input int tail);
        longint es, em, n;
        int k;
        rst_n    = 1'b0;
        sample_i = '0;
        repeat (3) @(negedge clk);
        check(rec_valid_o == 1'b0, "R1", "valid in reset", longint'(rec_valid_o), 0);
        check(rec_sum_o == '0 && rec_m2_o == '0, "R9", "outputs in reset",
              longint'(rec_m2_o), 0);
        sample_i = DATA_W'(pat(p, 0));
        rst_n    = 1'b1;
        for (int c = 0; c < ns + LEVELS + 1; c++) begin
            @(negedge clk);
            sample_i = DATA_W'(pat(p, c + 1));
            n = longint'(c) - LEVELS - 1;
            if (n >= 0 && ((n + 1) % BLK) == 0) begin
                k = int'((n + 1) / BLK) - 1;
                check(rec_valid_o == 1'b1, (k == 0) ? "R2" : "R3", "record missing",
                      longint'(rec_valid_o), 1);
                expect_block(p, k, es, em);
                check($signed(rec_sum_o) == es, (p == 2) ? "R7" : "R4", "block sum",
                      longint'($signed(rec_sum_o)), es);
                check(longint'(rec_m2_o) == em, (p == 2) ? "R7" : mreq, "block m2",
                      longint'(rec_m2_o), em);
            end else begin
                check(rec_valid_o == 1'b0, (n < BLK - 1) ? "R1" : "R3", "stray record",
                      longint'(rec_valid_o), 0);
                check(rec_sum_o == '0 && rec_m2_o == '0, "R9", "idle outputs",
                      longint'(rec_sum_o), 0);
            end
        end
        // run into the middle of the next block before the following reset (R8)
        repeat (tail) @(negedge clk);
    endtask

    initial begin
        run_phase(0, 256,  "R6", 3);
        run_phase(1, 512,  "R5", 5);
        run_phase(2, 480,  "R7", 2);
        run_phase(3, 2048, "R6", 6);  // R8: each phase starts from a mid-block reset
        run_phase(4, 64,   "R6", 1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule